// File: doc/BRIEF.md
# Dual-Bank Register Access Steering

This block sits behind the byte-level front end of a serial-control slave in a device that drives two output links. Each link has its own copy of a small set of per-link registers. The front end has already matched the device address and decoded the transfer into a register offset, write data and a one-cycle read or write strobe. A flag on the same cycle says whether the primary ID or the secondary ID matched. The block decides which copy of a per-link register a transfer reaches. It holds the shared bank-select register and returns registered read data together with an accept flag.

The steering follows the bank-select register and a dual-link mode input. With dual-link operation off, bank 1 cannot be reached. When both select bits are set, reads and writes behave differently: a write reaches both copies in one cycle, and a read returns the bank 1 copy. A direct-ID bit gives a second way in. When it is set, the secondary device ID is answered and leads to bank 1, the primary ID leads to bank 0, and the two select bits no longer choose a bank.

Top module: `dual_bank_reg_steer`

## Requirements
- R1: While reset is asserted and after it is released, the bank-select register reads 0x01, every per-link register in both banks reads 0x00, and ack_o and rdata_o are 0.
- R2: The bank-select register is global, at offset 0x1E. Only bits [2:0] are stored and bits [7:3] read as 0. It can be read and written through either accepted ID, and it changes only on an accepted write to 0x1E.
- R3: With dual mode on and bit 2 clear, a per-link read returns bank 1 when bit 1 is set (including when bits 1 and 0 are both set) and returns bank 0 otherwise.
- R4: With dual mode on and bit 2 clear, a per-link write updates every bank whose select bit is set, and both banks in the same cycle when bits 1 and 0 are both set. When bits 1 and 0 are both clear, it updates bank 0.
- R5: With dual mode on and bit 2 set, transfers through the secondary ID are accepted and reach only bank 1, and transfers through the primary ID reach only bank 0, whatever bits 1 and 0 hold.
- R6: With dual mode off, every per-link read and write reaches bank 0 and bank 1 never changes, whatever the bank-select register holds.
- R7: A transfer through the secondary ID is refused when bit 2 is clear or dual mode is off. A refused transfer gives ack_o = 0, rdata_o = 0x00, and changes no register.
- R8: ack_o is 1 in the cycle after an accepted strobe and 0 otherwise. rdata_o carries the read value in the cycle after an accepted read and is 0x00 in every other cycle. Per-link registers sit at offsets 0x00 to 0x0F. Any offset that is neither per-link nor 0x1E is accepted, reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dual_mode_i | input | 1 | High when split or independent dual-link operation is active |
| id_sec_i | input | 1 | Transfer matched the secondary device ID (0: primary ID) |
| addr_i | input | 8 | Register offset |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | One-cycle read strobe |
| wr_i | input | 1 | One-cycle write strobe |
| ack_o | output | 1 | Transfer accepted (registered) |
| rdata_o | output | 8 | Read data (registered, 0 when there is no accepted read) |

## Verification
The properties assume that the front end never raises read and write in the same cycle. They also assume that id_sec_i and dual_mode_i are valid whenever a strobe is high, and that the strobes stay low while the internal reset is held. The stimulus drives every transfer as a single-cycle strobe with an idle cycle after it. It changes dual_mode_i only in idle cycles and leaves the strobes low around reset, so the refusal and bank-freeze properties are always judged against the settings that the transfer itself saw.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int NBANK = 2;
  localparam int SELW = 3;
  localparam logic [AW-1:0] SEL_OFS = 8'h1E;
  localparam logic [SELW-1:0] SEL_RST = 3'b001;

  typedef struct packed {
    logic             accept;
    logic             is_sel;
    logic             is_bank;
    logic [NBANK-1:0] wr_mask;
    logic             rd_bank;
  } route_t;
endpackage

// File: rtl/dbr_route.sv
module dbr_route
  import dbr_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic [SELW-1:0] sel_i,
  input  logic            dual_i,
  input  logic            sec_i,
  input  logic [AW-1:0]   addr_i,
  output route_t          route_o
);
  always_comb begin
    route_o = '0;
    route_o.accept  = !sec_i || (sel_i[2] && dual_i);
    route_o.is_sel  = (addr_i == SEL_OFS);
    route_o.is_bank = (int'(addr_i) < DEPTH);
    if (!dual_i) begin
      route_o.wr_mask = 2'b01;
      route_o.rd_bank = 1'b0;
    end else if (sel_i[2]) begin
      route_o.wr_mask = sec_i ? 2'b10 : 2'b01;
      route_o.rd_bank = sec_i;
    end else begin
      route_o.rd_bank = sel_i[1];
      route_o.wr_mask = (sel_i[1:0] == 2'b00) ? 2'b01 : sel_i[1:0];
    end
  end
endmodule

// File: rtl/dbr_bank.sv
module dbr_bank
  import dbr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_i,
  input  logic [IW-1:0]       idx_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic [DEPTH*DW-1:0] image_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];

  for (genvar g = 0; g < DEPTH; g++) begin : g_img
    assign image_o[g*DW +: DW] = mem_q[g];
  end
endmodule

// File: rtl/dual_bank_reg_steer.sv
module dual_bank_reg_steer
  import dbr_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dual_mode_i,
  input  logic          id_sec_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  input  logic          wr_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o
);
  localparam int IW = $clog2(DEPTH);

  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  logic [SELW-1:0] sel_q, sel_d;
  logic            ack_d;
  logic [DW-1:0]   rdata_d;
  route_t          route;
  logic            acc_rd, acc_wr;
  logic [NBANK-1:0] bank_we;
  logic [DW-1:0]   bank_rdata [NBANK];
  logic [DEPTH*DW-1:0] bank_image [NBANK];
  logic [DW-1:0]   rd_value;

  dbr_route #(.DEPTH(DEPTH)) u_route (
    .sel_i  (sel_q),
    .dual_i (dual_mode_i),
    .sec_i  (id_sec_i),
    .addr_i (addr_i),
    .route_o(route)
  );

  assign acc_rd = rd_i && route.accept;
  assign acc_wr = wr_i && route.accept;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_we[b] = acc_wr && route.is_bank && route.wr_mask[b];
    dbr_bank #(.DEPTH(DEPTH)) u_bank (
      .clk    (clk),
      .rst_n  (rst_q),
      .we_i   (bank_we[b]),
      .idx_i  (addr_i[IW-1:0]),
      .wdata_i(wdata_i),
      .rdata_o(bank_rdata[b]),
      .image_o(bank_image[b])
    );
  end

  always_comb begin
    sel_d = sel_q;
    if (acc_wr && route.is_sel) sel_d = wdata_i[SELW-1:0];

    rd_value = '0;
    if (route.is_sel)       rd_value = {{(DW-SELW){1'b0}}, sel_q};
    else if (route.is_bank) rd_value = bank_rdata[route.rd_bank];

    ack_d   = acc_rd || acc_wr;
    rdata_d = acc_rd ? rd_value : '0;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      sel_q   <= SEL_RST;
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      sel_q   <= sel_d;
      ack_o   <= ack_d;
      rdata_o <= rdata_d;
    end
  end
endmodule

// File: rtl/dual_bank_reg_steer_chk.sv
module dual_bank_reg_steer_chk
  import dbr_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic                clk,
  input logic                rst_q,
  input logic                dual_mode_i,
  input logic                id_sec_i,
  input logic [AW-1:0]       addr_i,
  input logic                rd_i,
  input logic                wr_i,
  input logic                ack_o,
  input logic [DW-1:0]       rdata_o,
  input logic [SELW-1:0]     sel_q,
  input logic [DEPTH*DW-1:0] bank1_image
);
  logic refused;
  assign refused = id_sec_i && !(sel_q[2] && dual_mode_i);

  assert_ack_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_q)
    ack_o |-> $past(rd_i || wr_i));

  assert_rdata_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_q)
    !rd_i |=> (rdata_o == '0));

  assert_refused_no_ack_R7: assert property (@(posedge clk) disable iff (!rst_q)
    ((rd_i || wr_i) && refused) |=> (!ack_o && rdata_o == '0));

  assert_refused_write_inert_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_i && refused) |=> ($stable(sel_q) && $stable(bank1_image)));

  assert_single_bank_frozen_R6: assert property (@(posedge clk) disable iff (!rst_q)
    !dual_mode_i |=> $stable(bank1_image));

  assert_sel_only_by_write_R2: assert property (@(posedge clk) disable iff (!rst_q)
    !(wr_i && addr_i == SEL_OFS) |=> $stable(sel_q));
endmodule

bind dual_bank_reg_steer dual_bank_reg_steer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_q      (rst_q),
  .dual_mode_i(dual_mode_i),
  .id_sec_i   (id_sec_i),
  .addr_i     (addr_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .ack_o      (ack_o),
  .rdata_o    (rdata_o),
  .sel_q      (sel_q),
  .bank1_image(bank_image[1])
);

// File: tb/dual_bank_reg_steer_test.sv
`timescale 1ns/1ps
module dual_bank_reg_steer_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       dual_mode_i, id_sec_i, rd_i, wr_i;
  logic [7:0] addr_i, wdata_i;
  logic       ack_o;
  logic [7:0] rdata_o;

  int applied = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_bank_reg_steer uut (
    .clk(clk), .rst_n(rst_n), .dual_mode_i(dual_mode_i), .id_sec_i(id_sec_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rd_i(rd_i), .wr_i(wr_i),
    .ack_o(ack_o), .rdata_o(rdata_o)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       wr;
    logic       sec;
    logic       dual;
    logic [7:0] addr;
    logic [7:0] data;
    logic       ack;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 49;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 1'b0, 1'b0, 1'b1, 8'h1E, 8'h00, 1'b1, 8'h01}, // R1 reset select
    '{4'd1, 1'b0, 1'b0, 1'b1, 8'h03, 8'h00, 1'b1, 8'h00}, // R1 reset bank
    '{4'd4, 1'b1, 1'b0, 1'b1, 8'h03, 8'h9A, 1'b1, 8'h00}, // R4 bank0
    '{4'd2, 1'b1, 1'b0, 1'b1, 8'h1E, 8'h02, 1'b1, 8'h00},
    '{4'd4, 1'b1, 1'b0, 1'b1, 8'h03, 8'h5C, 1'b1, 8'h00}, // R4 bank1
    '{4'd3, 1'b0, 1'b0, 1'b1, 8'h03, 8'h00, 1'b1, 8'h5C}, // R3
    '{4'd2, 1'b1, 1'b0, 1'b1, 8'h1E, 8'h01, 1'b1, 8'h00},
    '{4'd3, 1'b0, 1'b0, 1'b1, 8'h03, 8'h00, 1'b1, 8'h9A},
    '{4'd2, 1'b1, 1'b0, 1'b1, 8'h1E, 8'hFB, 1'b1, 8'h00}, // R2 upper bits dropped
    '{4'd2, 1'b0, 1'b0, 1'b1, 8'h1E, 8'h00, 1'b1, 8'h03},
    '{4'd3, 1'b0, 1'b0, 1'b1, 8'h03, 8'h00, 1'b1, 8'h5C}, // R3 both -> bank1
    '{4'd4, 1'b1, 1'b0, 1'b1, 8'h03, 8'h11, 1'b1, 8'h00}, // R4 both banks
    '{4'd2, 1'b1, 1'b0, 1'b1, 8'h1E, 8'h01, 1'b1, 8'h00},
    '{4'd4, 1'b0, 1'b0, 1'b1, 8'h03, 8'h00, 1'b1, 8'h11},
    '{4'd2, 1'b1, 1'b0, 1'b1, 8'h1E, 8'h02, 1'b1, 8'h00},
    '{4'd4, 1'b0, 1'b0, 1'b1, 8'h03, 8'h00, 1'b1, 8'h11},
    '{4'd2, 1'b1, 1'b0, 1'b1, 8'h1E, 8'h00, 1'b1, 8'h00},
    '{4'd4, 1'b1, 1'b0, 1'b1, 8'h03, 8'h22, 1'b1, 8'h00}, // R4 none -> bank0
    '{4'd4, 1'b0, 1'b0, 1'b1, 8'h03, 8'h00, 1'b1, 8'h22},
    '{4'd2, 1'b1, 1'b0, 1'b1, 8'h1E, 8'h02, 1'b1, 8'h00},
    '{4'd4, 1'b0, 1'b0, 1'b1, 8'h03, 8'h00, 1'b1, 8'h11},
    '{4'd7, 1'b0, 1'b1, 1'b1, 8'h03, 8'h00, 1'b0, 8'h00}, // R7 refused read
    '{4'd7, 1'b1, 1'b1, 1'b1, 8'h03, 8'h77, 1'b0, 8'h00}, // R7 refused write
    '{4'd7, 1'b0, 1'b0, 1'b1, 8'h03, 8'h00, 1'b1, 8'h11},
    '{4'd2, 1'b1, 1'b0, 1'b1, 8'h1E, 8'h04, 1'b1, 8'h00},
    '{4'd5, 1'b0, 1'b1, 1'b1, 8'h03, 8'h00, 1'b1, 8'h11}, // R5 secondary -> bank1
    '{4'd5, 1'b0, 1'b0, 1'b1, 8'h03, 8'h00, 1'b1, 8'h22}, // R5 primary -> bank0
    '{4'd5, 1'b1, 1'b1, 1'b1, 8'h03, 8'h33, 1'b1, 8'h00},
    '{4'd5, 1'b0, 1'b0, 1'b1, 8'h03, 8'h00, 1'b1, 8'h22},
    '{4'd5, 1'b0, 1'b1, 1'b1, 8'h03, 8'h00, 1'b1, 8'h33},
    '{4'd2, 1'b0, 1'b1, 1'b1, 8'h1E, 8'h00, 1'b1, 8'h04}, // R2 global via secondary
    '{4'd2, 1'b1, 1'b1, 1'b1, 8'h1E, 8'h07, 1'b1, 8'h00},
    '{4'd5, 1'b1, 1'b0, 1'b1, 8'h03, 8'h44, 1'b1, 8'h00}, // R5 select bits ignored
    '{4'd5, 1'b0, 1'b1, 1'b1, 8'h03, 8'h00, 1'b1, 8'h33},
    '{4'd5, 1'b0, 1'b0, 1'b1, 8'h03, 8'h00, 1'b1, 8'h44},
    '{4'd6, 1'b0, 1'b0, 1'b0, 8'h03, 8'h00, 1'b1, 8'h44}, // R6 single mode
    '{4'd7, 1'b0, 1'b1, 1'b0, 8'h03, 8'h00, 1'b0, 8'h00}, // R7 dual off
    '{4'd7, 1'b1, 1'b1, 1'b0, 8'h1E, 8'h00, 1'b0, 8'h00},
    '{4'd2, 1'b0, 1'b0, 1'b0, 8'h1E, 8'h00, 1'b1, 8'h07},
    '{4'd6, 1'b1, 1'b0, 1'b0, 8'h1E, 8'h02, 1'b1, 8'h00},
    '{4'd6, 1'b1, 1'b0, 1'b0, 8'h03, 8'h55, 1'b1, 8'h00},
    '{4'd6, 1'b0, 1'b0, 1'b0, 8'h03, 8'h00, 1'b1, 8'h55},
    '{4'd6, 1'b0, 1'b0, 1'b1, 8'h03, 8'h00, 1'b1, 8'h33}, // R6 bank1 untouched
    '{4'd8, 1'b0, 1'b0, 1'b1, 8'h40, 8'h00, 1'b1, 8'h00}, // R8 unmapped
    '{4'd8, 1'b1, 1'b0, 1'b1, 8'h40, 8'hAB, 1'b1, 8'h00},
    '{4'd8, 1'b0, 1'b0, 1'b1, 8'h40, 8'h00, 1'b1, 8'h00},
    '{4'd8, 1'b0, 1'b0, 1'b1, 8'h0F, 8'h00, 1'b1, 8'h00}, // R8 last per-link
    '{4'd8, 1'b1, 1'b0, 1'b1, 8'h0F, 8'hE1, 1'b1, 8'h00},
    '{4'd8, 1'b0, 1'b0, 1'b1, 8'h0F, 8'h00, 1'b1, 8'hE1}
  };

  task automatic check(input int req, input logic a_ack, input logic [7:0] a_dat,
                       input logic e_ack, input logic [7:0] e_dat);
    applied++;
    if (a_ack !== e_ack || a_dat !== e_dat) begin
      miscompares++;
      $display("FAIL R%0d: ack=%0b rdata=%02h expected ack=%0b rdata=%02h",
               req, a_ack, a_dat, e_ack, e_dat);
    end
  endtask

  task automatic xfer(input vec_t v);
    @(negedge clk);
    dual_mode_i = v.dual; id_sec_i = v.sec; addr_i = v.addr; wdata_i = v.data;
    rd_i = !v.wr; wr_i = v.wr;
    @(negedge clk);
    rd_i = 1'b0; wr_i = 1'b0;
    check(int'(v.req), ack_o, rdata_o, v.ack, v.exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 100000);
    miscompares++;
    $display("FAIL R8: watchdog expired, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; dual_mode_i = 1'b1; id_sec_i = 1'b0; rd_i = 1'b0; wr_i = 1'b0;
    addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk);
    check(1, ack_o, rdata_o, 1'b0, 8'h00); // R1 outputs in reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) xfer(VECS[i]);

    // R8 idle cycle: no strobe gives no ack and zero data
    @(negedge clk);
    check(8, ack_o, rdata_o, 1'b0, 8'h00);

    // R1 reset in the middle of a run restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(1, ack_o, rdata_o, 1'b0, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    xfer('{4'd1, 1'b0, 1'b0, 1'b1, 8'h1E, 8'h00, 1'b1, 8'h01});
    xfer('{4'd1, 1'b0, 1'b0, 1'b1, 8'h03, 8'h00, 1'b1, 8'h00});
    xfer('{4'd1, 1'b0, 1'b0, 1'b1, 8'h0F, 8'h00, 1'b1, 8'h00});
    xfer('{4'd2, 1'b1, 1'b0, 1'b1, 8'h1E, 8'h02, 1'b1, 8'h00});
    xfer('{4'd1, 1'b0, 1'b0, 1'b1, 8'h03, 8'h00, 1'b1, 8'h00}); // R1 bank1 cleared

    finish_run();
  end
endmodule